// File: doc/BRIEF.md
# Debug Run/Stop Controller

This block decides when a small processor core may fetch instructions while a debugger is attached. A debug command port carries halt, resume and single-step requests over a valid/ready handshake. The controller answers with a fetch enable, a registered stopped flag and, when an interrupt must be serviced while the core is parked, a one-cycle redirect request that carries the handler vector.

In the wait-style debug behaviour, the enable bit is set and both the internal and external debug mode bits are clear. An interrupt that arrives while the core is stopped is then serviced. Fetch resumes at the handler, and the return-from-interrupt sends the core back to the stopped state. Under external debug mode the core stays parked whatever interrupts arrive.

Instructions that the debugger inserts while the core is stopped are flagged so that the privilege check is skipped for them. Trace trigger events pass to the trigger output only while both debug mode bits are clear.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: A synchronous reset puts the controller in the running state, with fetch_en=1, stopped=0, redirect_valid=0 and cmd_ready=1.
- R2: A command is accepted when cmd_valid and cmd_ready are both high. The encodings are 2'b01 halt, 2'b10 resume and 2'b11 step, and 2'b00 does nothing. A halt accepted while running clears fetch_en from the next cycle. A resume accepted while stopped sets it again from the next cycle.
- R3: stopped follows the stopped state one cycle late. It rises one cycle after the controller enters the stopped state and falls one cycle after it leaves.
- R4: The wait-style behaviour is active when dwait_en=1, int_dbg_mode=0 and ext_dbg_mode=0. While it is active and the core is stopped, an interrupt request produces a one-cycle redirect_valid in the next cycle. In that same cycle fetch_en=1. redirect_vec is 0x100 for a critical request and 0x500 for an external request.
- R5: When critical and external requests arrive in the same cycle, the critical vector 0x100 is taken.
- R6: A rfi_retire strobe during a handler entered from the stopped state returns the controller to the stopped state in the next cycle, with fetch_en=0.
- R7: While stopped with wait-style behaviour inactive (dwait_en=0, or either mode bit set), interrupt requests are ignored. fetch_en stays 0 and no redirect occurs.
- R8: In a cycle where a stopped controller takes an interrupt, cmd_ready is 0, so the command is held off rather than lost.
- R9: A resume accepted during a handler makes the return-from-interrupt go to the running state. A halt accepted after it cancels that, and the return then goes to the stopped state. Either way the return takes effect in the cycle after rfi_retire.
- R10: A step command accepted while stopped enables fetch until one retire strobe is seen. fetch_en then returns to 0 in the next cycle.
- R11: priv_bypass equals stuff_insn while the controller is in the stopped state and is 0 otherwise.
- R12: trig_out equals trig_in when int_dbg_mode=0 and ext_dbg_mode=0, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Debug command present |
| cmd_op | input | 2 | Command code: 01 halt, 10 resume, 11 step |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| dwait_en | input | 1 | Enable for servicing interrupts while stopped |
| int_dbg_mode | input | 1 | Internal debug mode bit |
| ext_dbg_mode | input | 1 | External debug mode bit |
| crit_irq | input | 1 | Critical interrupt request |
| ext_irq | input | 1 | External interrupt request |
| retire | input | 1 | One instruction retired this cycle |
| rfi_retire | input | 1 | The retiring instruction is a return-from-interrupt |
| stuff_insn | input | 1 | An instruction inserted by the debugger is executing |
| trig_in | input | 1 | Raw trace trigger event |
| fetch_en | output | 1 | Instruction fetch permitted |
| redirect_valid | output | 1 | One-cycle request to jump to redirect_vec |
| redirect_vec | output | VEC_W | Handler address for the redirect |
| stopped | output | 1 | Registered stopped status |
| priv_bypass | output | 1 | Skip the privilege check for the inserted instruction |
| trig_out | output | 1 | Gated trace trigger |

## Verification
The assertions assume that rfi_retire is only seen while a handler runs, and that retire strobes come only while fetch is enabled. They also assume that interrupt requests and mode bits are synchronous to clk. The stimulus drives every input on the falling edge. It raises rfi_retire only in cycles where the expected state is the handler, and it raises retire only during a step or a handler. Mode bits change only while the core is parked, so an interrupt is never taken under a mode that changes in the same cycle.

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl #(
  parameter int VEC_W = 32,
  parameter logic [VEC_W-1:0] CRIT_VEC = 'h100,
  parameter logic [VEC_W-1:0] EXT_VEC  = 'h500
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  output logic             cmd_ready,
  input  logic             dwait_en,
  input  logic             int_dbg_mode,
  input  logic             ext_dbg_mode,
  input  logic             crit_irq,
  input  logic             ext_irq,
  input  logic             retire,
  input  logic             rfi_retire,
  input  logic             stuff_insn,
  input  logic             trig_in,
  output logic             fetch_en,
  output logic             redirect_valid,
  output logic [VEC_W-1:0] redirect_vec,
  output logic             stopped,
  output logic             priv_bypass,
  output logic             trig_out
);

  localparam logic [1:0] OP_HALT = 2'b01;
  localparam logic [1:0] OP_RESUME = 2'b10;
  localparam logic [1:0] OP_STEP = 2'b11;

  typedef enum logic [1:0] {S_RUN, S_STOP, S_STEP, S_ISR} state_e;

  state_e state_q, state_d;
  logic   leave_q, leave_d;

  wire dbg_quiet = !int_dbg_mode && !ext_dbg_mode;
  wire dw_active = dwait_en && dbg_quiet;
  wire take_irq  = (state_q == S_STOP) && dw_active && (crit_irq || ext_irq);
  wire fire      = cmd_valid && cmd_ready;
  wire do_halt   = fire && cmd_op == OP_HALT;
  wire do_resume = fire && cmd_op == OP_RESUME;
  wire do_step   = fire && cmd_op == OP_STEP;

  assign cmd_ready   = !take_irq;
  assign fetch_en    = state_q != S_STOP;
  assign priv_bypass = (state_q == S_STOP) && stuff_insn;
  assign trig_out    = trig_in && dbg_quiet;

  always_comb begin
    state_d = state_q;
    leave_d = 1'b0;
    case (state_q)
      S_RUN:  if (do_halt) state_d = S_STOP;
      S_STOP: begin
        if (take_irq)       state_d = S_ISR;
        else if (do_resume) state_d = S_RUN;
        else if (do_step)   state_d = S_STEP;
      end
      S_STEP: if (do_halt || retire) state_d = S_STOP;
      S_ISR: begin
        leave_d = do_resume ? 1'b1 : (do_halt ? 1'b0 : leave_q);
        if (rfi_retire) state_d = leave_d ? S_RUN : S_STOP;
      end
      default: state_d = S_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= S_RUN;
      leave_q        <= 1'b0;
      stopped        <= 1'b0;
      redirect_valid <= 1'b0;
      redirect_vec   <= '0;
    end else begin
      state_q        <= state_d;
      leave_q        <= leave_d;
      stopped        <= state_q == S_STOP;
      redirect_valid <= take_irq;
      if (take_irq) redirect_vec <= crit_irq ? CRIT_VEC : EXT_VEC;
    end
  end

  p_redir_from_stop_r4: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> $past(state_q == S_STOP) && fetch_en);

  p_crit_first_r5: assert property (@(posedge clk) disable iff (rst)
    (redirect_valid && $past(crit_irq)) |-> redirect_vec == CRIT_VEC);

  p_quiet_when_inactive_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_STOP && !dw_active) |=> !redirect_valid);

  p_held_off_r8: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> $past(!cmd_ready));

  p_step_once_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_STEP && retire && !cmd_valid) |=> !fetch_en);

  p_bypass_parked_r11: assert property (@(posedge clk) disable iff (rst)
    priv_bypass |-> !fetch_en);

  p_trig_gate_r12: assert property (@(posedge clk) disable iff (rst)
    trig_out |-> !int_dbg_mode && !ext_dbg_mode);

endmodule

// File: tb/dbg_halt_ctrl_tb.sv
module dbg_halt_ctrl_tb_top;
  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 0, dwait_en = 0, int_dbg_mode = 0, ext_dbg_mode = 0;
  logic [1:0] cmd_op = 0;
  logic crit_irq = 0, ext_irq = 0, retire = 0, rfi_retire = 0, stuff_insn = 0, trig_in = 0;
  logic cmd_ready, fetch_en, redirect_valid, stopped, priv_bypass, trig_out;
  logic [31:0] redirect_vec;
  int total = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dbg_halt_ctrl dut_i (.*);

  // {valid, op[1:0], dw, idm, edm, crit, ext, ret, rfi, exp_fetch, exp_redir, exp_crit_vec, exp_stopped}
  localparam int NV = 22;
  localparam logic [13:0] VEC [NV] = '{
    14'b1_01_100_00_00_0000, // R2 halt
    14'b0_00_100_00_00_0001, // R3 stopped rises
    14'b0_00_100_01_00_1101, // R4 external vector
    14'b0_00_100_00_10_1000, // R3 stopped falls
    14'b0_00_100_00_11_0000, // R6 return to stop
    14'b0_00_100_11_00_1111, // R5 critical wins
    14'b1_10_100_00_00_1000, // R9 resume recorded
    14'b1_01_100_00_00_1000, // R9 halt cancels
    14'b0_00_100_00_11_0000, // R9 back to stop
    14'b1_10_100_10_00_1111, // R8 irq beats command
    14'b1_10_100_00_00_1000, // R9 resume in handler
    14'b0_00_100_00_11_1000, // R9 return to run
    14'b1_01_100_00_00_0000, // R2 halt
    14'b0_00_101_01_00_0001, // R7 ext mode blocks
    14'b0_00_110_10_00_0001, // R7 int mode blocks
    14'b0_00_000_10_00_0001, // R7 enable clear
    14'b1_11_100_00_00_1001, // R10 step
    14'b0_00_100_00_00_1000, // R10 waits for retire
    14'b0_00_100_00_10_0000, // R10 stop after retire
    14'b0_00_100_00_00_0001, // R3
    14'b1_10_100_00_00_1001, // R2 resume
    14'b0_00_100_00_00_1000  // R2 running
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 fetch", fetch_en, 1); chk("R1 stopped", stopped, 0);
    chk("R1 redir", redirect_valid, 0); chk("R1 ready", cmd_ready, 1);
    for (int i = 0; i < NV; i++) begin
      logic [13:0] v;
      v = VEC[i];
      {cmd_valid, cmd_op, dwait_en, int_dbg_mode, ext_dbg_mode, crit_irq, ext_irq, retire, rfi_retire} = v[13:4];
      @(negedge clk);
      {cmd_valid, crit_irq, ext_irq, retire, rfi_retire} = '0;
      chk($sformatf("row%0d fetch", i), fetch_en, v[3]);
      chk($sformatf("row%0d redir", i), redirect_valid, v[2]);
      if (v[2]) chk($sformatf("row%0d vec", i), redirect_vec, v[1] ? 32'h100 : 32'h500);
      chk($sformatf("row%0d stopped", i), stopped, v[0]);
    end
    // R12 trigger gating
    trig_in = 1; int_dbg_mode = 0; ext_dbg_mode = 0; #1 chk("R12 pass", trig_out, 1);
    int_dbg_mode = 1; #1 chk("R12 idm", trig_out, 0);
    int_dbg_mode = 0; ext_dbg_mode = 1; #1 chk("R12 edm", trig_out, 0);
    ext_dbg_mode = 0; trig_in = 0;
    // R11 bypass only when stopped
    stuff_insn = 1; #1 chk("R11 running", priv_bypass, 0);
    cmd_valid = 1; cmd_op = 2'b01; @(negedge clk); cmd_valid = 0;
    chk("R11 stopped", priv_bypass, 1);
    stuff_insn = 0; #1 chk("R11 idle", priv_bypass, 0);
    // R8 ready drops while interrupt is taken
    dwait_en = 1; crit_irq = 1; #1 chk("R8 ready low", cmd_ready, 0);
    crit_irq = 0; #1 chk("R8 ready high", cmd_ready, 1);
    // R1 reset from stopped
    rst = 1; @(negedge clk); @(negedge clk); rst = 0;
    chk("R1 fetch after reset", fetch_en, 1);
    chk("R1 stopped after reset", stopped, 0);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule